// File: doc/BRIEF.md
# Three-Wire Half-Duplex Serial Master

This block drives a sensor bus made of an active-low chip select, a serial clock and one shared data line. The data line is split at the block edge into an output value, an output enable and an input value. The pad that joins them sits outside the block. A single command port takes an operation code, an 8-bit register address and an 8-bit write value. The block runs one of three sequences:

- a register write: the address byte, then the data byte, both driven by the master;
- a register read: the address byte driven, then the line is released and one byte is received;
- a resynchronisation pulse on chip select alone.

All bus timing is counted in system clock cycles. The clocks-per-microsecond parameter sets the scale, and a per-phase parameter gives each phase's length in microseconds. A clock low phase for a written bit lasts 2 µs. A clock low phase for a read bit lasts 1 µs. Every high phase lasts 1 µs. A 4 µs pause follows every written byte, and it also serves as the turnaround before a read. A 1 µs tail follows the received byte. The resync pulse lasts 1 µs. Each operation ends with a one-cycle done strobe, at the same edge at which chip select returns high.

Top module: `tw_serial_master`

## Requirements
- R1: After reset, bus_csn = 1, bus_sclk = 1, bus_sd_oe = 0, busy = 0, done = 0 and rd_data = 0.
- R2: Written bits are shifted out most-significant bit first. In a write, the address byte is sent first and the data byte follows, 16 bits in total. Each bit is valid on bus_sd_out with bus_sd_oe = 1 when bus_sclk rises.
- R3: Each written bit holds bus_sclk low for 2·CLK_PER_US cycles, then high for CLK_PER_US cycles.
- R4: In a read, after the address byte the block keeps bus_sd_oe = 0 for 8 bits. Each bit holds bus_sclk low for CLK_PER_US cycles. bus_sd_in is sampled in the last low cycle, most-significant bit first. The received byte appears on rd_data.
- R5: After each written byte, bus_sclk stays high with bus_sd_oe = 0 for 4·CLK_PER_US cycles. Together with the last bit's high phase, the longest clock-high run inside chip select is therefore 5·CLK_PER_US cycles.
- R6: bus_csn is low for exactly 56·CLK_PER_US cycles in a write and 45·CLK_PER_US cycles in a read. The read figure includes a 1 µs tail after the received byte.
- R7: A resync drives bus_csn low for CLK_PER_US cycles with no clock edge.
- R8: The cmd_op encoding is 2'b00 write, 2'b01 read, 2'b10 resync. The code 2'b11 is ignored: busy stays 0 and bus_csn stays 1.
- R9: busy is 1 from the cycle after a command is accepted until the done cycle. A command presented while busy is 1 is ignored.
- R10: done is a single-cycle pulse that coincides with bus_csn returning high. In that cycle busy is already 0, and a command presented then is accepted.
- R11: rd_data changes only in the done cycle of a read, and holds its value through later writes and resyncs.
- R12: bus_sd_oe is never 1 while bus_csn is 1, and bus_sclk is never 0 while bus_csn is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command request, taken when busy is 0 |
| cmd_op | input | 2 | Operation code (see R8) |
| cmd_addr | input | 8 | Register address byte |
| cmd_wdata | input | 8 | Data byte for a write |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion strobe |
| rd_data | output | 8 | Byte received by the last read |
| bus_csn | output | 1 | Chip select, active low |
| bus_sclk | output | 1 | Serial clock, idles high |
| bus_sd_out | output | 1 | Data line output value |
| bus_sd_oe | output | 1 | Data line output enable |
| bus_sd_in | input | 1 | Data line input value |

## Verification
Two events can share one cycle: the done strobe of one operation and the acceptance of the next command. The bench waits for done and, in that same cycle, presents a new write. This happens right after a read. The bench then checks four things:
- busy was low during the done cycle;
- done is low and busy is high one cycle later;
- the read's chip-select window kept its full 45·CLK_PER_US length;
- the following write emits exactly its own address and data bits.

// File: rtl/tw_pkg.sv
// Package: shared operation codes and sequencer states for the three-wire
// serial master. Assumes 2-bit operation codes as listed in the brief.
package tw_pkg;

    typedef enum logic [1:0] {
        OP_WRITE  = 2'b00,
        OP_READ   = 2'b01,
        OP_RESYNC = 2'b10,
        OP_NONE   = 2'b11
    } tw_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SYNC,
        ST_BIT_LO,
        ST_BIT_HI,
        ST_GAP,
        ST_TAIL
    } tw_state_e;

endpackage

// File: rtl/tw_delay.sv
// Module: phase timer. Counts down from a loaded value. It reports
// expiry while the count is zero, so a phase loaded with N-1 lasts N
// cycles. Assumes the sequencer reloads it on every phase change.
module tw_delay #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);

    logic [W-1:0] count;

    // Load a new phase length or step the count towards zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (load)
            count <= load_val;
        else if (count != '0)
            count <= count - 1'b1;
    end

    assign expired = (count == '0);

    // Phase lengths (R3) rely on a strict one-per-cycle decrement.
    p_count_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && count != '0) |=> (count == $past(count) - 1'b1));

    // An expired timer stays at zero until reloaded.
    p_hold_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && count == '0) |=> (count == '0));

endmodule

// File: rtl/tw_shreg.sv
// Module: byte shift register shared by transmit and receive. It shifts
// left, so the MSB leaves first, and new bits enter at the LSB. Assumes
// load has priority over shift.
module tw_shreg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         shift_en,
    input  logic         ser_in,
    output logic         msb,
    output logic [W-1:0] par
);

    // Parallel load or one-place left shift.
    always_ff @(posedge clk) begin
        if (!rst_n)
            par <= '0;
        else if (load)
            par <= load_val;
        else if (shift_en)
            par <= {par[W-2:0], ser_in};
    end

    assign msb = par[W-1];

    // MSB-first order (R2, R4): each shift moves every bit up one place.
    p_shift_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && !load) |=> (par[W-1:1] == $past(par[W-2:0])));

    // A shift inserts the sampled input at the bottom (R4).
    p_shift_in_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && !load) |=> (par[0] == $past(ser_in)));

endmodule

// File: rtl/tw_serial_master.sv
// Module: three-wire half-duplex serial master. It runs register writes,
// register reads and chip-select resync pulses on a bus with one shared
// data line. Phase lengths are microsecond parameters scaled by
// CLK_PER_US. Assumes an external pad joins bus_sd_out/bus_sd_oe/bus_sd_in
// and that the slave drives the line while bus_sd_oe is low.
module tw_serial_master
    import tw_pkg::*;
#(
    parameter int CLK_PER_US  = 4,
    parameter int BYTE_W      = 8,
    parameter int WR_LOW_US   = 2,
    parameter int RD_LOW_US   = 1,
    parameter int HIGH_US     = 1,
    parameter int GAP_US      = 4,
    parameter int TAIL_US     = 1,
    parameter int RESYNC_US   = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [BYTE_W-1:0] cmd_addr,
    input  logic [BYTE_W-1:0] cmd_wdata,
    output logic              busy,
    output logic              done,
    output logic [BYTE_W-1:0] rd_data,
    output logic              bus_csn,
    output logic              bus_sclk,
    output logic              bus_sd_out,
    output logic              bus_sd_oe,
    input  logic              bus_sd_in
);

    // Phase lengths in system clock cycles.
    localparam int WRL_C  = CLK_PER_US * WR_LOW_US;
    localparam int RDL_C  = CLK_PER_US * RD_LOW_US;
    localparam int HI_C   = CLK_PER_US * HIGH_US;
    localparam int GAP_C  = CLK_PER_US * GAP_US;
    localparam int TAIL_C = CLK_PER_US * TAIL_US;
    localparam int SYNC_C = CLK_PER_US * RESYNC_US;
    localparam int MAX_A  = (WRL_C > RDL_C) ? WRL_C : RDL_C;
    localparam int MAX_B  = (HI_C > GAP_C) ? HI_C : GAP_C;
    localparam int MAX_C  = (TAIL_C > SYNC_C) ? TAIL_C : SYNC_C;
    localparam int MAX_AB = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int MAX_CYC = (MAX_AB > MAX_C) ? MAX_AB : MAX_C;
    localparam int TW     = $clog2(MAX_CYC + 1);
    localparam int BCW    = $clog2(BYTE_W);
    localparam logic [BCW-1:0] LAST_BIT = BCW'(BYTE_W - 1);

    tw_state_e         st, st_n;
    tw_op_e            op_r;
    logic [BYTE_W-1:0] wdata_r;
    logic              second_byte;
    logic              rd_phase;
    logic [BCW-1:0]    bit_cnt;
    logic              oe_r;

    logic              tmr_load;
    logic [TW-1:0]     tmr_val;
    logic              tmr_exp;
    logic              sh_load;
    logic [BYTE_W-1:0] sh_val;
    logic              sh_shift;
    logic              sh_msb;
    logic [BYTE_W-1:0] sh_par;
    logic              start;

    assign start = cmd_valid && (st == ST_IDLE) && (tw_op_e'(cmd_op) != OP_NONE);

    tw_delay #(.W(TW)) i_delay (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_exp)
    );

    tw_shreg #(.W(BYTE_W)) i_shreg (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (sh_load),
        .load_val (sh_val),
        .shift_en (sh_shift),
        .ser_in   (rd_phase ? bus_sd_in : 1'b0),
        .msb      (sh_msb),
        .par      (sh_par)
    );

    // Next state plus timer and shifter control for the coming phase.
    always_comb begin
        st_n     = st;
        tmr_load = 1'b0;
        tmr_val  = '0;
        sh_load  = 1'b0;
        sh_val   = cmd_addr;
        sh_shift = 1'b0;
        unique case (st)
            ST_IDLE: begin
                if (start) begin
                    tmr_load = 1'b1;
                    if (tw_op_e'(cmd_op) == OP_RESYNC) begin
                        st_n    = ST_SYNC;
                        tmr_val = TW'(SYNC_C - 1);
                    end else begin
                        st_n    = ST_BIT_LO;
                        tmr_val = TW'(WRL_C - 1);
                        sh_load = 1'b1;
                    end
                end
            end
            ST_SYNC: begin
                if (tmr_exp) st_n = ST_IDLE;
            end
            ST_BIT_LO: begin
                if (tmr_exp) begin
                    st_n     = ST_BIT_HI;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(HI_C - 1);
                    sh_shift = rd_phase;
                end
            end
            ST_BIT_HI: begin
                if (tmr_exp) begin
                    tmr_load = 1'b1;
                    if (bit_cnt != '0) begin
                        st_n     = ST_BIT_LO;
                        tmr_val  = rd_phase ? TW'(RDL_C - 1) : TW'(WRL_C - 1);
                        sh_shift = !rd_phase;
                    end else if (rd_phase) begin
                        st_n    = ST_TAIL;
                        tmr_val = TW'(TAIL_C - 1);
                    end else begin
                        st_n    = ST_GAP;
                        tmr_val = TW'(GAP_C - 1);
                    end
                end
            end
            ST_GAP: begin
                if (tmr_exp) begin
                    if (op_r == OP_WRITE && !second_byte) begin
                        st_n     = ST_BIT_LO;
                        tmr_load = 1'b1;
                        tmr_val  = TW'(WRL_C - 1);
                        sh_load  = 1'b1;
                        sh_val   = wdata_r;
                    end else if (op_r == OP_READ) begin
                        st_n     = ST_BIT_LO;
                        tmr_load = 1'b1;
                        tmr_val  = TW'(RDL_C - 1);
                    end else begin
                        st_n = ST_IDLE;
                    end
                end
            end
            ST_TAIL: begin
                if (tmr_exp) st_n = ST_IDLE;
            end
            default: st_n = ST_IDLE;
        endcase
    end

    // Sequencer registers and registered bus outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st          <= ST_IDLE;
            op_r        <= OP_NONE;
            wdata_r     <= '0;
            second_byte <= 1'b0;
            rd_phase    <= 1'b0;
            bit_cnt     <= '0;
            bus_csn     <= 1'b1;
            bus_sclk    <= 1'b1;
            oe_r        <= 1'b0;
            done        <= 1'b0;
            rd_data     <= '0;
        end else begin
            st   <= st_n;
            done <= 1'b0;
            unique case (st)
                ST_IDLE: begin
                    if (start) begin
                        op_r        <= tw_op_e'(cmd_op);
                        wdata_r     <= cmd_wdata;
                        second_byte <= 1'b0;
                        rd_phase    <= 1'b0;
                        bit_cnt     <= LAST_BIT;
                        bus_csn     <= 1'b0;
                        if (tw_op_e'(cmd_op) != OP_RESYNC) begin
                            bus_sclk <= 1'b0;
                            oe_r     <= 1'b1;
                        end
                    end
                end
                ST_SYNC: begin
                    if (tmr_exp) begin
                        bus_csn <= 1'b1;
                        done    <= 1'b1;
                    end
                end
                ST_BIT_LO: begin
                    if (tmr_exp) bus_sclk <= 1'b1;
                end
                ST_BIT_HI: begin
                    if (tmr_exp) begin
                        if (bit_cnt != '0) begin
                            bus_sclk <= 1'b0;
                            bit_cnt  <= bit_cnt - 1'b1;
                        end else begin
                            oe_r <= 1'b0;
                        end
                    end
                end
                ST_GAP: begin
                    if (tmr_exp) begin
                        if (op_r == OP_WRITE && !second_byte) begin
                            second_byte <= 1'b1;
                            bit_cnt     <= LAST_BIT;
                            bus_sclk    <= 1'b0;
                            oe_r        <= 1'b1;
                        end else if (op_r == OP_READ) begin
                            rd_phase <= 1'b1;
                            bit_cnt  <= LAST_BIT;
                            bus_sclk <= 1'b0;
                        end else begin
                            bus_csn <= 1'b1;
                            done    <= 1'b1;
                        end
                    end
                end
                ST_TAIL: begin
                    if (tmr_exp) begin
                        rd_data <= sh_par;
                        bus_csn <= 1'b1;
                        done    <= 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    assign busy       = (st != ST_IDLE);
    assign bus_sd_oe  = oe_r;
    assign bus_sd_out = oe_r & sh_msb;

    // The data line is only driven inside chip select.
    p_oe_inside_cs_r12: assert property (@(posedge clk) disable iff (!rst_n)
        bus_csn |-> !bus_sd_oe);

    // The clock only goes low inside chip select.
    p_sclk_inside_cs_r12: assert property (@(posedge clk) disable iff (!rst_n)
        bus_csn |-> bus_sclk);

    // Lines are at rest whenever no operation is running (R1).
    p_idle_lines_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (bus_csn && bus_sclk && !bus_sd_oe));

    // The completion strobe never lasts two cycles.
    p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // Done arrives together with chip select rising.
    p_done_with_cs_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (bus_csn && $past(!bus_csn)));

    // The latched command cannot change while an operation runs.
    p_cmd_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(op_r) && $stable(wdata_r)));

    // Read data only moves at the end of a read.
    p_rdata_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rd_data) |-> (done && op_r == OP_READ));

    // The reserved code never starts an operation.
    p_reserved_op_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cmd_valid && cmd_op == 2'b11) |=> !busy);

endmodule

// File: tb/test_tw_serial_master.sv
// Bench: models the slave side of the bus, sweeps bit patterns through
// writes and reads, and measures every phase length in clock cycles.
module test_tw_serial_master;

    localparam int CLK_PERIOD = 10;
    localparam int CPU        = 2;
    localparam int WR_CS_LEN  = 56 * CPU;
    localparam int RD_CS_LEN  = 45 * CPU;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [1:0] cmd_op = 2'b00;
    logic [7:0] cmd_addr = 8'h00;
    logic [7:0] cmd_wdata = 8'h00;
    logic       busy, done;
    logic [7:0] rd_data;
    logic       bus_csn, bus_sclk, bus_sd_out, bus_sd_oe, bus_sd_in;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    tw_serial_master #(.CLK_PER_US(CPU)) i_tw_serial_master (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_valid  (cmd_valid),
        .cmd_op     (cmd_op),
        .cmd_addr   (cmd_addr),
        .cmd_wdata  (cmd_wdata),
        .busy       (busy),
        .done       (done),
        .rd_data    (rd_data),
        .bus_csn    (bus_csn),
        .bus_sclk   (bus_sclk),
        .bus_sd_out (bus_sd_out),
        .bus_sd_oe  (bus_sd_oe),
        .bus_sd_in  (bus_sd_in)
    );

    // Bus monitor state, sampled on falling clock edges.
    logic        prev_csn = 1'b1, prev_sclk = 1'b1, lo_oe = 1'b0;
    int          lo_len = 0, cs_len = 0, last_cs_len = 0;
    int          wcnt = 0, rcnt = 0, hi_run = 0, hi_max = 0;
    int          wlo_min = 0, wlo_max = 0, rlo_min = 0, rlo_max = 0;
    int          oe_viol = 0, sclk_viol = 0;
    logic [15:0] wcap = 16'h0;
    logic [7:0]  resp = 8'h00;

    // Slave model: presents bit rcnt of the response, MSB first.
    assign bus_sd_in = (rcnt < 8) ? resp[3'(7 - rcnt)] : 1'b0;

    // Monitor: measures phase lengths and captures driven bits.
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_csn && !bus_csn) begin
                cs_len = 0; wcnt = 0; rcnt = 0; wcap = 16'h0;
                wlo_min = 1 << 20; wlo_max = 0; rlo_min = 1 << 20; rlo_max = 0;
                hi_run = 0; hi_max = 0; lo_len = 0;
            end
            if (!bus_csn) cs_len++;
            if (!prev_csn && bus_csn) last_cs_len = cs_len;
            if (!bus_sclk) begin
                lo_len++;
                lo_oe = bus_sd_oe;
            end
            if (!prev_sclk && bus_sclk) begin
                if (lo_oe) begin
                    wcap = {wcap[14:0], bus_sd_out};
                    wcnt++;
                    if (lo_len < wlo_min) wlo_min = lo_len;
                    if (lo_len > wlo_max) wlo_max = lo_len;
                end else begin
                    rcnt++;
                    if (lo_len < rlo_min) rlo_min = lo_len;
                    if (lo_len > rlo_max) rlo_max = lo_len;
                end
                lo_len = 0;
            end
            if (!bus_csn && bus_sclk) begin
                hi_run++;
                if (hi_run > hi_max) hi_max = hi_run;
            end else begin
                hi_run = 0;
            end
            if (bus_csn && bus_sd_oe) oe_viol++;
            if (bus_csn && !bus_sclk) sclk_viol++;
            prev_csn  = bus_csn;
            prev_sclk = bus_sclk;
        end
    end

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
        end
    endtask

    task automatic issue(input logic [1:0] op, input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_wdata = d;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    // Waits for done, then checks one more cycle for a single-cycle pulse.
    task automatic wait_done(input string req);
        int n = 0;
        while (done !== 1'b1 && n < 5000) begin
            @(negedge clk);
            n++;
        end
        chk(done === 1'b1, req, 0, 1);
        chk(busy === 1'b0, "R10 busy low in done cycle", busy, 0);
        @(negedge clk);
        chk(done === 1'b0, "R10 done single cycle", done, 0);
    endtask

    function automatic logic [7:0] pat(input int i);
        case (i)
            0: return 8'h00;
            1: return 8'hFF;
            2: return 8'hA5;
            3: return 8'h5A;
            default: return 8'(1 << (i - 4));
        endcase
    endfunction

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(bus_csn === 1'b1, "R1 csn", bus_csn, 1);
        chk(bus_sclk === 1'b1, "R1 sclk", bus_sclk, 1);
        chk(bus_sd_oe === 1'b0, "R1 oe", bus_sd_oe, 0);
        chk(busy === 1'b0, "R1 busy", busy, 0);
        chk(done === 1'b0, "R1 done", done, 0);
        chk(rd_data === 8'h00, "R1 rd_data", rd_data, 0);

        // Write sweep (R2, R3, R5, R6)
        for (int i = 0; i < 12; i++) begin
            logic [7:0] a, d;
            a = pat(i);
            d = ~pat(11 - i);
            issue(2'b00, a, d);
            chk(busy === 1'b1, "R9 busy after accept", busy, 1);
            wait_done("R10 write done");
            chk(wcap === {a, d}, "R2 write bits", wcap, {a, d});
            chk(wcnt == 16 && rcnt == 0, "R2 write bit count", wcnt, 16);
            chk(wlo_min == 2 * CPU && wlo_max == 2 * CPU, "R3 write low length", wlo_max, 2 * CPU);
            chk(hi_max == 5 * CPU, "R5 gap after write byte", hi_max, 5 * CPU);
            chk(last_cs_len == WR_CS_LEN, "R6 write cs length", last_cs_len, WR_CS_LEN);
        end

        // Read sweep (R4, R5, R6)
        for (int i = 0; i < 12; i++) begin
            logic [7:0] a;
            a = ~pat(i);
            resp = pat(i) ^ 8'h3C;
            issue(2'b01, a, 8'hEE);
            wait_done("R10 read done");
            chk(rd_data === resp, "R4 read data", rd_data, resp);
            chk(wcap[7:0] === a && wcnt == 8, "R4 read address bits", wcap[7:0], a);
            chk(rcnt == 8, "R4 read bit count", rcnt, 8);
            chk(rlo_min == CPU && rlo_max == CPU, "R4 read low length", rlo_max, CPU);
            chk(hi_max == 5 * CPU, "R5 turnaround gap", hi_max, 5 * CPU);
            chk(last_cs_len == RD_CS_LEN, "R6 read cs length", last_cs_len, RD_CS_LEN);
        end

        // R7 resync pulse; R11 rd_data held through it
        resp = 8'h00;
        issue(2'b10, 8'h12, 8'h34);
        wait_done("R10 resync done");
        chk(last_cs_len == CPU, "R7 resync cs length", last_cs_len, CPU);
        chk(wcnt == 0 && rcnt == 0, "R7 no clock edge", wcnt + rcnt, 0);
        chk(rd_data === (pat(11) ^ 8'h3C), "R11 rd_data after resync", rd_data, pat(11) ^ 8'h3C);

        // R8 reserved code ignored
        begin
            int seen = 0;
            @(negedge clk);
            cmd_valid = 1'b1; cmd_op = 2'b11; cmd_addr = 8'h77;
            repeat (10) begin
                @(negedge clk);
                if (busy !== 1'b0 || bus_csn !== 1'b1) seen++;
            end
            cmd_valid = 1'b0;
            chk(seen == 0, "R8 reserved op ignored", seen, 0);
        end

        // R9 command while busy ignored; R11 rd_data held through a write
        issue(2'b00, 8'hC3, 8'h96);
        repeat (5) @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 2'b01; cmd_addr = 8'h11;
        @(negedge clk);
        cmd_valid = 1'b0;
        wait_done("R9 write done");
        chk(wcap === 16'hC396 && wcnt == 16 && rcnt == 0, "R9 busy command ignored", wcap, 16'hC396);
        chk(last_cs_len == WR_CS_LEN, "R9 cs length unchanged", last_cs_len, WR_CS_LEN);
        repeat (20) @(negedge clk);
        chk(busy === 1'b0 && bus_csn === 1'b1, "R9 no deferred start", busy, 0);
        chk(rd_data === (pat(11) ^ 8'h3C), "R11 rd_data after write", rd_data, pat(11) ^ 8'h3C);

        // R10 command in the done cycle of a read
        resp = 8'h69;
        issue(2'b01, 8'h0F, 8'h00);
        while (done !== 1'b1) @(negedge clk);
        chk(busy === 1'b0, "R10 busy low at done", busy, 0);
        cmd_valid = 1'b1; cmd_op = 2'b00; cmd_addr = 8'hB4; cmd_wdata = 8'h2D;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(done === 1'b0 && busy === 1'b1, "R10 accepted in done cycle", busy, 1);
        chk(last_cs_len == RD_CS_LEN, "R10 read cs length", last_cs_len, RD_CS_LEN);
        chk(rd_data === 8'h69, "R4 read before back-to-back", rd_data, 8'h69);
        wait_done("R10 back-to-back done");
        chk(wcap === 16'hB42D && wcnt == 16, "R10 back-to-back write bits", wcap, 16'hB42D);
        chk(last_cs_len == WR_CS_LEN, "R10 back-to-back cs length", last_cs_len, WR_CS_LEN);

        // R12 line discipline over the whole run
        chk(oe_viol == 0, "R12 oe outside cs", oe_viol, 0);
        chk(sclk_viol == 0, "R12 sclk outside cs", sclk_viol, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule